// File: doc/BRIEF.md
# Integer ALU with Condition Flags and Relation Test

This block is a purely combinational 32-bit arithmetic and logic unit. It takes two operands and a 3-bit operation code. It returns a result word and four status flags: negative, zero, carry and overflow. A single adder serves addition, subtraction and both set-less-than forms. For a subtraction, B is inverted and the adder's carry input is forced high.

A relation test sits beside the ALU and reads the four flags it produces. It takes a 3-bit relation code and a signed/unsigned select, and asserts `rel_true` when the chosen relation between A and B holds. This answer is meaningful after a subtraction. A datapath uses it by issuing a subtract and reading `rel_true` in the same cycle.

Top module: `flag_alu`

## Requirements
- R1: With `op_sel`=000 (add), `result` is A+B modulo 2^32 and `flag_c` is the carry out of bit 31.
- R2: With `op_sel`=001 (subtract), `result` is A−B modulo 2^32, computed as A + ~B + 1. `flag_c` is that adder's carry out, which is 1 exactly when A ≥ B unsigned.
- R3: For add and subtract, `flag_v` is 1 exactly when the true two's-complement result lies outside the signed 32-bit range.
- R4: With `op_sel`=010 (AND), 011 (OR) or 100 (XOR), `result` is the bitwise function of A and B, and `flag_c` and `flag_v` are 0.
- R5: For every operation, `flag_n` equals `result[31]` and `flag_z` is 1 exactly when `result` is all zeros.
- R6: With `op_sel`=101 (signed set-less-than), `result` is 1 when A < B as signed numbers and 0 otherwise, with bits 31..1 zero. `flag_c` and `flag_v` are 0.
- R7: With `op_sel`=110 (unsigned set-less-than), `result` is 1 when A < B as unsigned numbers and 0 otherwise, with bits 31..1 zero. `flag_c` and `flag_v` are 0.
- R8: After a subtract with `rel_signed`=1, `rel_true` gives the signed relation selected by `rel_sel`: 000 eq, 001 ne, 010 lt, 011 le, 100 gt, 101 ge.
- R9: After a subtract with `rel_signed`=0, `rel_true` gives the same six relations under the unsigned interpretation.
- R10: `op_sel`=111 gives a zero result with `flag_c`=`flag_v`=0. `rel_sel` values 110 and 111 give `rel_true`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 32 | Operand A |
| b_in | input | 32 | Operand B |
| op_sel | input | 3 | Operation code |
| rel_sel | input | 3 | Relation code for the relation test |
| rel_signed | input | 1 | 1 selects signed relations, 0 unsigned |
| result | output | 32 | Operation result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| rel_true | output | 1 | Selected relation holds |

## Verification
The block has no registers, so every output is due in the same cycle as the inputs that produce it, with no latency to count. The driver applies a new operand set just after a rising edge and queues the expected values. The monitor compares all outputs at the following falling edge, after the combinational paths have settled and before the next stimulus arrives. The relation output is compared only for subtract items, where it carries meaning, and every code from 000 to 111 is swept for both signednesses.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [2:0]   op_sel,
  input  logic [2:0]   rel_sel,
  input  logic         rel_signed,
  output logic [W-1:0] result,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v,
  output logic         rel_true
);
  localparam logic [2:0] OP_ADD  = 3'b000;
  localparam logic [2:0] OP_SUB  = 3'b001;
  localparam logic [2:0] OP_AND  = 3'b010;
  localparam logic [2:0] OP_OR   = 3'b011;
  localparam logic [2:0] OP_XOR  = 3'b100;
  localparam logic [2:0] OP_SLTS = 3'b101;
  localparam logic [2:0] OP_SLTU = 3'b110;
  localparam int MSB = W - 1;

  logic         is_slt, use_sub, arith, ovf, cout, lt;
  logic [W-1:0] b_eff, sum;

  assign is_slt  = (op_sel == OP_SLTS) || (op_sel == OP_SLTU);
  assign use_sub = (op_sel == OP_SUB) || is_slt;
  assign arith   = (op_sel == OP_ADD) || (op_sel == OP_SUB);
  assign b_eff   = use_sub ? ~b_in : b_in;
  assign {cout, sum} = {1'b0, a_in} + {1'b0, b_eff} + {{W{1'b0}}, use_sub};
  assign ovf     = (a_in[MSB] == b_eff[MSB]) && (sum[MSB] != a_in[MSB]);

  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB: result = sum;
      OP_AND:         result = a_in & b_in;
      OP_OR:          result = a_in | b_in;
      OP_XOR:         result = a_in ^ b_in;
      OP_SLTS:        result = {{(W-1){1'b0}}, sum[MSB] ^ ovf};
      OP_SLTU:        result = {{(W-1){1'b0}}, ~cout};
      default:        result = '0;
    endcase
  end

  assign flag_n = result[MSB];
  assign flag_z = ~|result;
  assign flag_c = arith & cout;
  assign flag_v = arith & ovf;

  assign lt = rel_signed ? (flag_n ^ flag_v) : ~flag_c;

  always_comb begin
    case (rel_sel)
      3'd0:    rel_true = flag_z;
      3'd1:    rel_true = ~flag_z;
      3'd2:    rel_true = lt;
      3'd3:    rel_true = flag_z | lt;
      3'd4:    rel_true = ~flag_z & ~lt;
      3'd5:    rel_true = ~lt;
      default: rel_true = 1'b0;
    endcase
  end

  always_comb begin
    if (!$isunknown({a_in, b_in, op_sel})) begin
      // R6 R7
      slt_upper_chk: assert (!is_slt || result[MSB:1] == '0);
      // R4
      logic_cv_chk: assert (arith || (!flag_c && !flag_v));
      // R3
      no_overflow_chk: assert (!(op_sel == OP_ADD && a_in[MSB] != b_in[MSB]) || !flag_v);
      // R2
      sub_equal_chk: assert (!(op_sel == OP_SUB && a_in == b_in) || (flag_z && flag_c));
      // R5
      zero_sign_chk: assert (!flag_z || !flag_n);
    end
  end
endmodule

// File: tb/flag_alu_tb.sv
module flag_alu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a_in = '0, b_in = '0;
  logic [2:0]  op_sel = '0, rel_sel = '0;
  logic        rel_signed = 1'b0;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_c, flag_v, rel_true;

  typedef struct {
    logic [31:0] res;
    logic        n, z, c, v, cond, chk_cond;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flag_alu u_dut (
    .a_in(a_in), .b_in(b_in), .op_sel(op_sel), .rel_sel(rel_sel),
    .rel_signed(rel_signed), .result(result), .flag_n(flag_n),
    .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v), .rel_true(rel_true)
  );

  function automatic item_t model(logic [31:0] a, logic [31:0] b, logic [2:0] op,
                                  logic [2:0] rel, logic sgn, string tag);
    item_t it;
    longint sa, sb, sr;
    logic lt_r, eq_r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    it.c = 1'b0; it.v = 1'b0; it.cond = 1'b0; it.chk_cond = 1'b0; it.tag = tag;
    case (op)
      3'd0: begin it.res = a + b; it.c = (33'(a) + 33'(b)) >= 33'h1_0000_0000;
                  sr = sa + sb; it.v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648); end
      3'd1: begin it.res = a - b; it.c = (a >= b);
                  sr = sa - sb; it.v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648); end
      3'd2: it.res = a & b;
      3'd3: it.res = a | b;
      3'd4: it.res = a ^ b;
      3'd5: it.res = {31'd0, sa < sb};
      3'd6: it.res = {31'd0, a < b};
      default: it.res = '0;
    endcase
    it.n = it.res[31];
    it.z = (it.res == '0);
    if (op == 3'd1) begin
      it.chk_cond = 1'b1;
      eq_r = (a == b);
      lt_r = sgn ? (sa < sb) : (a < b);
      case (rel)
        3'd0: it.cond = eq_r;
        3'd1: it.cond = !eq_r;
        3'd2: it.cond = lt_r;
        3'd3: it.cond = lt_r || eq_r;
        3'd4: it.cond = !lt_r && !eq_r;
        3'd5: it.cond = !lt_r;
        default: it.cond = 1'b0;
      endcase
    end
    return it;
  endfunction

  task automatic drive(logic [31:0] a, logic [31:0] b, logic [2:0] op,
                       logic [2:0] rel, logic sgn, string tag);
    @(posedge clk);
    a_in = a; b_in = b; op_sel = op; rel_sel = rel; rel_signed = sgn;
    q.push_back(model(a, b, op, rel, sgn, tag));
  endtask

  initial begin : monitor
    item_t e;
    forever begin
      @(negedge clk);
      if (!rst && q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (result !== e.res || flag_n !== e.n || flag_z !== e.z ||
            flag_c !== e.c || flag_v !== e.v || (e.chk_cond && rel_true !== e.cond)) begin
          errors++;
          $display("FAIL %s: got res=%h nzcv=%b%b%b%b rel=%b, exp res=%h nzcv=%b%b%b%b rel=%b",
                   e.tag, result, flag_n, flag_z, flag_c, flag_v, rel_true,
                   e.res, e.n, e.z, e.c, e.v, e.cond);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    logic [31:0] pa [8];
    logic [31:0] pb [8];
    pa = '{32'd5, 32'd7, 32'hFFFF_FFFF, 32'd1, 32'h8000_0000, 32'h7FFF_FFFF, 32'd0, 32'hFFFF_FFFE};
    pb = '{32'd7, 32'd5, 32'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'd0, 32'hFFFF_FFFE};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive(32'd0, 32'd0, 3'd0, 3'd0, 1'b0, "R5 baseline zero add");
    drive(32'd3, 32'd4, 3'd0, 3'd0, 1'b0, "R1 small add");
    drive(32'hFFFF_FFFF, 32'd1, 3'd0, 3'd0, 1'b0, "R1 R5 carry wrap to zero");
    drive(32'h7FFF_FFFF, 32'd1, 3'd0, 3'd0, 1'b0, "R3 positive add overflow");
    drive(32'h8000_0000, 32'h8000_0000, 3'd0, 3'd0, 1'b0, "R3 negative add overflow");
    drive(32'd10, 32'd3, 3'd1, 3'd0, 1'b0, "R2 sub no borrow");
    drive(32'd3, 32'd10, 3'd1, 3'd0, 1'b0, "R2 R5 sub borrow negative");
    drive(32'h8000_0000, 32'd1, 3'd1, 3'd0, 1'b0, "R3 sub overflow");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 3'd2, 3'd0, 1'b0, "R4 and");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 3'd3, 3'd0, 1'b0, "R4 or");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 3'd4, 3'd0, 1'b0, "R4 xor");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd4, 3'd0, 1'b0, "R4 R5 xor to zero");
    drive(32'hFFFF_FFFF, 32'd1, 3'd5, 3'd0, 1'b0, "R6 signed slt true");
    drive(32'd1, 32'hFFFF_FFFF, 3'd5, 3'd0, 1'b0, "R6 signed slt false");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 3'd5, 3'd0, 1'b0, "R6 signed slt overflow case");
    drive(32'hFFFF_FFFF, 32'd1, 3'd6, 3'd0, 1'b0, "R7 unsigned slt false");
    drive(32'd1, 32'hFFFF_FFFF, 3'd6, 3'd0, 1'b0, "R7 unsigned slt true");
    drive(32'd9, 32'd9, 3'd6, 3'd0, 1'b0, "R7 unsigned slt equal");
    drive(32'h1234_5678, 32'hFFFF_FFFF, 3'd7, 3'd0, 1'b0, "R10 reserved op");
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 8; i++)
        for (int r = 0; r < 8; r++)
          drive(pa[i], pb[i], 3'd1, 3'(r), 1'(s),
                (r > 5) ? "R10 unused relation code" : (s == 1 ? "R8 signed relation" : "R9 unsigned relation"));
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule